// File: doc/BRIEF.md
# External Interrupt Line Router

This block turns pin activity on several 16-pin GPIO ports into sixteen interrupt lines and one combined interrupt request. Each line picks any port. Within that port it can only pick a pin from its own group of four: line `n` sits in group `n/4` and reaches only pins `4*(n/4)` to `4*(n/4)+3`. So the routing works in two stages, first the port and then the pin within the group.

The routed pin is compared with its value on the previous clock. A rising or falling change can set the line's pending flag, depending on the line's two edge enables. An interrupt enable per line gates the pending flags onto the single request output. Software sets all of this up through a small synchronous register bus with write enable, a 3-bit word address and 32-bit data. The same bus reads back the configuration and the pending flags, and writing ones to the flag word clears pending flags. The pin inputs are assumed to be synchronous to the block clock already.

Top module: `extirq_router`

## Requirements
- R1: After synchronous reset, every readable word returns zero and `irq` is low.
- R2: The word map is: 0 = port selects of lines 0..7, 1 = port selects of lines 8..15, 2 = pin selects of lines 0..7, 3 = pin selects of lines 8..15, 4 = rising enables, 5 = falling enables, 6 = interrupt enables, 7 = pending flags. In words 0..3, each 2-bit field sits at bit `(line mod 8)*2`. In words 4..7, line `n` is bit `n`. Reads combinationally return the current contents, and bits 31:16 always read zero.
- R3: Line `n` watches pin `4*(n/4) + pinsel` of port `portsel`. On the `pins` bus, port `p` pin `k` is bit `p*16 + k`.
- R4: When a line's rising enable is set and its routed pin goes from 0 to 1, the pending flag is set on the same clock edge that first sees the new pin value.
- R5: When a line's falling enable is set and its routed pin goes from 1 to 0, the pending flag is set in the same way.
- R6: With both enables set, either edge sets the flag. An edge whose enable is clear leaves the flag unchanged.
- R7: Writing word 7 clears each pending flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R8: If an enabled edge and a clear of the same line occur on the same clock, the flag stays set.
- R9: `irq` is high exactly when some line has both its pending flag and its interrupt enable set. Pending flags are set whether or not the interrupt enable is set.
- R10: On the first clock after reset, and on the first clock after a line's port or pin select changes, the line takes the new pin value without reporting an edge.
- R11: Activity on a pin that no line routes leaves every pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pins | input | 64 | Four ports of 16 pins, port p pin k at bit p*16+k |
| irq | output | 1 | Combined interrupt request |

## Verification
Any fault in the select registers or the routing mux shows up one clock after a toggle of the intended pin. It appears as a missing bit in word 7, or as a flag raised by a pin that should be invisible. If the previous-value register is not re-primed after a reroute, a phantom flag appears on the clock after the select write. An error in the pending update shows up in the next read of word 7 and on `irq` in that same cycle: a clear that wins over a colliding edge, or write-zero bits that clear flags. The bench compares every read and `irq` every cycle against a cycle-level model, so each of these faults is reported within one or two cycles.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int DEF_NUM_PORTS  = 4;
    localparam int DEF_PORT_PINS  = 16;
    localparam int DEF_NUM_LINES  = 16;
    localparam int DEF_GROUP_SIZE = 4;
    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PSEL_LO = 3'd0,
        A_PSEL_HI = 3'd1,
        A_PIN_LO  = 3'd2,
        A_PIN_HI  = 3'd3,
        A_RISE    = 3'd4,
        A_FALL    = 3'd5,
        A_IEN     = 3'd6,
        A_FLAG    = 3'd7
    } reg_addr_e;

    function automatic int group_base(input int line, input int group_size);
        return (line / group_size) * group_size;
    endfunction

endpackage

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = DEF_NUM_LINES,
    parameter int PSEL_W    = 2,
    parameter int PIN_W     = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic [NUM_LINES-1:0]              pend,
    output logic [NUM_LINES-1:0][PSEL_W-1:0]  port_sel,
    output logic [NUM_LINES-1:0][PIN_W-1:0]   pin_sel,
    output logic [NUM_LINES-1:0]              rise_en,
    output logic [NUM_LINES-1:0]              fall_en,
    output logic [NUM_LINES-1:0]              irq_en,
    output logic [NUM_LINES-1:0]              clr,
    output logic [DATA_W-1:0]                 rdata
);
    localparam int HALF = NUM_LINES / 2;

    logic [DATA_W-1:0] psel_lo_w, psel_hi_w, pin_lo_w, pin_hi_w;
    logic              unused_wdata_bits;

    assign unused_wdata_bits = ^wdata[DATA_W-1:NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            port_sel <= '0;
            pin_sel  <= '0;
            rise_en  <= '0;
            fall_en  <= '0;
            irq_en   <= '0;
        end else if (wr_en) begin
            case (addr)
                A_PSEL_LO: for (int i = 0; i < HALF; i++)
                               port_sel[i] <= wdata[i*PSEL_W +: PSEL_W];
                A_PSEL_HI: for (int i = 0; i < HALF; i++)
                               port_sel[i+HALF] <= wdata[i*PSEL_W +: PSEL_W];
                A_PIN_LO:  for (int i = 0; i < HALF; i++)
                               pin_sel[i] <= wdata[i*PIN_W +: PIN_W];
                A_PIN_HI:  for (int i = 0; i < HALF; i++)
                               pin_sel[i+HALF] <= wdata[i*PIN_W +: PIN_W];
                A_RISE:    rise_en <= wdata[NUM_LINES-1:0];
                A_FALL:    fall_en <= wdata[NUM_LINES-1:0];
                A_IEN:     irq_en  <= wdata[NUM_LINES-1:0];
                default:   ;
            endcase
        end
    end

    assign clr = (wr_en && addr == A_FLAG) ? wdata[NUM_LINES-1:0] : '0;

    always_comb begin
        psel_lo_w = '0;
        psel_hi_w = '0;
        pin_lo_w  = '0;
        pin_hi_w  = '0;
        for (int i = 0; i < HALF; i++) begin
            psel_lo_w[i*PSEL_W +: PSEL_W] = port_sel[i];
            psel_hi_w[i*PSEL_W +: PSEL_W] = port_sel[i+HALF];
            pin_lo_w[i*PIN_W +: PIN_W]    = pin_sel[i];
            pin_hi_w[i*PIN_W +: PIN_W]    = pin_sel[i+HALF];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_PSEL_LO: rdata = psel_lo_w;
            A_PSEL_HI: rdata = psel_hi_w;
            A_PIN_LO:  rdata = pin_lo_w;
            A_PIN_HI:  rdata = pin_hi_w;
            A_RISE:    rdata[NUM_LINES-1:0] = rise_en;
            A_FALL:    rdata[NUM_LINES-1:0] = fall_en;
            A_IEN:     rdata[NUM_LINES-1:0] = irq_en;
            default:   rdata[NUM_LINES-1:0] = pend;
        endcase
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (port_sel == '0 && pin_sel == '0 && rise_en == '0
                        && fall_en == '0 && irq_en == '0));

    // R2
    ien_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_IEN) |=> irq_en == $past(wdata[NUM_LINES-1:0]));

endmodule

// File: rtl/extirq_route.sv
module extirq_route
    import extirq_pkg::*;
#(
    parameter int NUM_PORTS  = DEF_NUM_PORTS,
    parameter int PORT_PINS  = DEF_PORT_PINS,
    parameter int NUM_LINES  = DEF_NUM_LINES,
    parameter int GROUP_SIZE = DEF_GROUP_SIZE,
    parameter int PSEL_W     = 2,
    parameter int PIN_W      = 2
) (
    input  logic [NUM_PORTS*PORT_PINS-1:0]    pins,
    input  logic [NUM_LINES-1:0][PSEL_W-1:0]  port_sel,
    input  logic [NUM_LINES-1:0][PIN_W-1:0]   pin_sel,
    output logic [NUM_LINES-1:0]              routed
);
    localparam int PIDX_W = $clog2(PORT_PINS);

    logic [NUM_PORTS-1:0][PORT_PINS-1:0] pins_2d;
    assign pins_2d = pins;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        localparam logic [PIDX_W-1:0] BASE = PIDX_W'(group_base(n, GROUP_SIZE));
        logic [PORT_PINS-1:0] port_row;
        logic [PIDX_W-1:0]    idx;
        assign port_row  = pins_2d[port_sel[n]];
        assign idx       = BASE + PIDX_W'(pin_sel[n]);
        assign routed[n] = port_row[idx];
    end

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = DEF_NUM_LINES,
    parameter int SEL_W     = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_LINES-1:0]            routed,
    input  logic [NUM_LINES-1:0][SEL_W-1:0] sel,
    input  logic [NUM_LINES-1:0]            rise_en,
    input  logic [NUM_LINES-1:0]            fall_en,
    input  logic [NUM_LINES-1:0]            clr,
    output logic [NUM_LINES-1:0]            pend
);
    logic [NUM_LINES-1:0][SEL_W-1:0] sel_q;
    logic [NUM_LINES-1:0]            prev;
    logic [NUM_LINES-1:0]            armed;
    logic [NUM_LINES-1:0]            det;

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            det[i] = armed[i] && (sel[i] == sel_q[i]) &&
                     ((rise_en[i] && !prev[i] &&  routed[i]) ||
                      (fall_en[i] &&  prev[i] && !routed[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            prev  <= '0;
            armed <= '0;
            pend  <= '0;
        end else begin
            sel_q <= sel;
            prev  <= routed;
            armed <= '1;
            pend  <= (pend & ~clr) | det;
        end
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
        // R4
        set_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
            (!pend[n] && !$past(rst)) ##1 pend[n] |-> $past(routed[n]) != $past(routed[n], 2));

        // R7
        clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[n] && !det[n]) |=> !pend[n]);

        // R8
        collide_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[n] && det[n]) |=> pend[n]);

        // R10
        reroute_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (sel[n] != $past(sel[n])) |=> pend[n] == $past(pend[n] & ~clr[n]));
    end

endmodule

// File: rtl/extirq_router.sv
module extirq_router
    import extirq_pkg::*;
#(
    parameter int NUM_PORTS  = DEF_NUM_PORTS,
    parameter int PORT_PINS  = DEF_PORT_PINS,
    parameter int NUM_LINES  = DEF_NUM_LINES,
    parameter int GROUP_SIZE = DEF_GROUP_SIZE
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    input  logic [NUM_PORTS*PORT_PINS-1:0] pins,
    output logic                           irq
);
    localparam int PSEL_W = $clog2(NUM_PORTS);
    localparam int PIN_W  = $clog2(GROUP_SIZE);
    localparam int SEL_W  = PSEL_W + PIN_W;

    logic [NUM_LINES-1:0][PSEL_W-1:0] port_sel;
    logic [NUM_LINES-1:0][PIN_W-1:0]  pin_sel;
    logic [NUM_LINES-1:0][SEL_W-1:0]  sel;
    logic [NUM_LINES-1:0]             rise_en, fall_en, irq_en, clr, pend, routed;

    extirq_regs #(
        .NUM_LINES(NUM_LINES), .PSEL_W(PSEL_W), .PIN_W(PIN_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pend(pend), .port_sel(port_sel), .pin_sel(pin_sel),
        .rise_en(rise_en), .fall_en(fall_en), .irq_en(irq_en),
        .clr(clr), .rdata(rdata)
    );

    extirq_route #(
        .NUM_PORTS(NUM_PORTS), .PORT_PINS(PORT_PINS), .NUM_LINES(NUM_LINES),
        .GROUP_SIZE(GROUP_SIZE), .PSEL_W(PSEL_W), .PIN_W(PIN_W)
    ) u_route (
        .pins(pins), .port_sel(port_sel), .pin_sel(pin_sel), .routed(routed)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_sel
        assign sel[n] = {port_sel[n], pin_sel[n]};
    end

    extirq_detect #(
        .NUM_LINES(NUM_LINES), .SEL_W(SEL_W)
    ) u_detect (
        .clk(clk), .rst(rst), .routed(routed), .sel(sel),
        .rise_en(rise_en), .fall_en(fall_en), .clr(clr), .pend(pend)
    );

    assign irq = |(pend & irq_en);

    // R9
    irq_reset_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

endmodule

// File: tb/extirq_router_bench.sv
module extirq_router_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [63:0] pins;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [31:0] last_rd;

    logic [31:0] mr [7];
    logic [15:0] mpend, mprev, marmed;
    logic [3:0]  msel_q [16];

    always #5 clk = ~clk;

    extirq_router u_extirq_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pins(pins), .irq(irq)
    );

    function automatic logic [1:0] f_port(input int n);
        logic [31:0] w = (n < 8) ? mr[0] : mr[1];
        return w[(n%8)*2 +: 2];
    endfunction

    function automatic logic [1:0] f_pin(input int n);
        logic [31:0] w = (n < 8) ? mr[2] : mr[3];
        return w[(n%8)*2 +: 2];
    endfunction

    function automatic logic f_routed(input int n, input logic [63:0] p);
        return p[int'(f_port(n))*16 + (n/4)*4 + int'(f_pin(n))];
    endfunction

    function automatic logic [31:0] f_read(input logic [2:0] a);
        if (a == 3'd7) return {16'h0, mpend};
        return mr[a];
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 7; i++) mr[i] = '0;
        for (int i = 0; i < 16; i++) msel_q[i] = '0;
        mpend = '0; mprev = '0; marmed = '0;
    endtask

    task automatic model_step(input logic we, input logic [2:0] a,
                              input logic [31:0] d, input logic [63:0] p);
        logic [15:0] det, clrm;
        clrm = (we && a == 3'd7) ? d[15:0] : 16'h0;
        for (int n = 0; n < 16; n++) begin
            logic r = f_routed(n, p);
            logic [3:0] s = {f_port(n), f_pin(n)};
            det[n] = marmed[n] && (s == msel_q[n]) &&
                     ((mr[4][n] && !mprev[n] && r) || (mr[5][n] && mprev[n] && !r));
            msel_q[n] = s;
            mprev[n]  = r;
        end
        marmed = '1;
        mpend  = (mpend & ~clrm) | det;
        if (we && a != 3'd7) mr[a] = d & 32'h0000_FFFF;
    endtask

    // Starts and ends on a falling edge.
    task automatic tick(input logic we, input logic [2:0] a,
                        input logic [31:0] d, input logic [63:0] p);
        wr_en = we; addr = a; wdata = d; pins = p;
        #1;
        last_rd = rdata;
        chk("R2 read data", rdata, f_read(a));
        @(posedge clk);
        model_step(we, a, d, p);
        @(negedge clk);
        chk("R9 irq", {31'h0, irq}, {31'h0, |(mpend & mr[6][15:0])});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] p;
        void'($urandom(32'd4242));
        rst = 1'b1; wr_en = 0; addr = 0; wdata = 0; pins = 64'h0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        p = 64'h0;

        // R1: reset state of every word and of irq
        for (int a = 0; a < 8; a++) begin
            tick(0, 3'(a), 0, p);
            chk("R1 reset word", last_rd, 32'h0);
        end
        chk("R1 irq low", {31'h0, irq}, 32'h0);

        // R2: upper bits of a select word read zero
        tick(1, 3'd0, 32'hFFFF_FFFF, p);
        tick(0, 3'd0, 0, p);
        chk("R2 upper bits zero", last_rd, 32'h0000_FFFF);
        tick(1, 3'd0, 0, p);

        // line 5: port 2, pin field 3 -> pin 7 of port 2 = bit 39
        tick(1, 3'd0, 32'h0000_0800, p);
        tick(1, 3'd2, 32'h0000_0C00, p);
        tick(1, 3'd4, 32'h0000_0020, p);
        tick(0, 3'd7, 0, p);
        tick(0, 3'd7, 0, p);

        p[39] = 1'b1;
        tick(0, 3'd7, 0, p);
        tick(0, 3'd7, 0, p);
        chk("R3 R4 rising on routed pin", last_rd, 32'h20);
        chk("R9 no irq while disabled", {31'h0, irq}, 32'h0);
        tick(1, 3'd6, 32'h20, p);
        chk("R9 irq with enable", {31'h0, irq}, 32'h1);

        tick(1, 3'd7, 32'h20, p);
        tick(0, 3'd7, 0, p);
        chk("R7 clear", last_rd, 32'h0);

        p[23] = 1'b1; p[38] = 1'b1; p[3] = 1'b1;
        tick(0, 3'd7, 0, p);
        tick(0, 3'd7, 0, p);
        chk("R11 unrouted pins", last_rd, 32'h0);

        p[39] = 1'b0;
        tick(0, 3'd7, 0, p);
        tick(0, 3'd7, 0, p);
        chk("R6 fall ignored, rise only", last_rd, 32'h0);

        p[39] = 1'b1;
        tick(0, 3'd7, 0, p);
        tick(1, 3'd7, 32'h0000_FFDF, p);
        tick(0, 3'd7, 0, p);
        chk("R7 zero bits keep flag", last_rd, 32'h20);

        tick(1, 3'd5, 32'h20, p);
        p[39] = 1'b0;
        tick(1, 3'd7, 32'h20, p);
        tick(0, 3'd7, 0, p);
        chk("R8 edge beats clear", last_rd, 32'h20);
        tick(1, 3'd7, 32'h20, p);

        tick(1, 3'd4, 32'h0, p);
        p[39] = 1'b1;
        tick(0, 3'd7, 0, p);
        tick(0, 3'd7, 0, p);
        chk("R5 rise ignored, fall only", last_rd, 32'h0);
        p[39] = 1'b0;
        tick(0, 3'd7, 0, p);
        tick(0, 3'd7, 0, p);
        chk("R5 falling sets flag", last_rd, 32'h20);
        tick(1, 3'd7, 32'h20, p);

        tick(1, 3'd4, 32'h20, p);
        p[36] = 1'b1;
        tick(0, 3'd7, 0, p);
        tick(1, 3'd2, 32'h0, p);
        tick(0, 3'd7, 0, p);
        tick(0, 3'd7, 0, p);
        chk("R10 reroute silent", last_rd, 32'h0);
        p[36] = 1'b0;
        tick(0, 3'd7, 0, p);
        tick(0, 3'd7, 0, p);
        chk("R6 R10 detection resumes", last_rd, 32'h20);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [63:0] flip;
            logic        we;
            logic [2:0]  a;
            logic [31:0] d;
            flip = {$urandom & $urandom & $urandom & $urandom,
                    $urandom & $urandom & $urandom & $urandom};
            p  = p ^ flip;
            we = ($urandom % 5) == 0;
            a  = 3'($urandom % 8);
            d  = $urandom;
            tick(we, a, d, p);
        end

        // R10: reset with pins held high reports nothing
        rst = 1'b1; pins = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        model_reset();
        rst = 1'b0;
        p = 64'hFFFF_FFFF_FFFF_FFFF;
        tick(1, 3'd4, 32'hFFFF, p);
        tick(1, 3'd5, 32'hFFFF, p);
        tick(0, 3'd7, 0, p);
        chk("R10 no edge after reset", last_rd, 32'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule